// File: doc/BRIEF.md
# Pixel-Doubling Palette Video Scan-Out

This block turns a small indexed-colour framebuffer into a full video raster. It keeps the picture in on-chip RAM at half the output resolution in each direction. Each stored entry is a 7-bit colour index. While it scans, the block shows every stored pixel twice along a line and reads every stored line twice, so a 512×384 picture fills a 1024×768 display. Each index passes through a writable 128-entry colour table that gives 4 bits for each of red, green and blue. The block also produces active-low horizontal and vertical sync and a data-valid strobe.

A rendering engine writes pixels through a separate write port that runs independently of the scan. The same applies to the colour table. Indices 0 to 126 normally hold escape-time shades and index 127 marks points inside the set, but the hardware treats all 128 entries the same way. The framebuffer stays on chip so that video reads never stall for DRAM refresh.

The framebuffer size and the porch and sync lengths are parameters. The defaults describe a 32×24 picture on a 64×48 raster, which keeps elaboration small. The 60 Hz XGA setting is FB_W=512, FB_H=384, H_FP=24, H_SYNC=136, H_BP=160, V_FP=3, V_SYNC=6 and V_BP=29.

Top module: `vscan_doubler`

## Requirements
- R1: While `rst` is high the outputs are held at blank: `de`=0, `hsync_n`=1, `vsync_n`=1 and RGB=0. After release, the raster origin (column 0, line 0) appears on the outputs at the second rising edge.
- R2: A line lasts 2*FB_W+H_FP+H_SYNC+H_BP clocks. Columns are counted from 0 with the visible ones first. `hsync_n` is low for the H_SYNC columns that begin at column 2*FB_W+H_FP.
- R3: A frame lasts 2*FB_H+V_FP+V_SYNC+V_BP lines. `vsync_n` is low for the V_SYNC lines that begin at line 2*FB_H+V_FP.
- R4: `de` is high exactly when the column is below 2*FB_W and the line is below 2*FB_H.
- R5: At visible column h and line v, the index shown is the framebuffer word at address (v>>1)*FB_W+(h>>1). FB_W is a power of two, so the address is the row bits above the column bits.
- R6: The colour shown for index i is colour-table entry i. Bits 11:8 drive `red`, bits 7:4 drive `green` and bits 3:0 drive `blue`.
- R7: Whenever `de` is low, `red`, `green` and `blue` are all zero.
- R8: Sync, `de` and colour all describe the raster position held by the scan counters two clocks earlier, so they stay mutually aligned.
- R9: A framebuffer write (`fb_we`) or a colour-table write (`pal_we`) takes effect on the next clock edge, whether or not `rst` is high. The new content appears the next time the scan reaches that entry.
- R10: Index 127 (all ones) addresses an ordinary writable table entry, so the table holds 128 colours.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset of the scan and output pipeline |
| fb_we | input | 1 | Framebuffer write strobe |
| fb_waddr | input | log2(FB_W)+log2(FB_H) | Framebuffer write address, row above column |
| fb_wdata | input | IDX_W | Colour index to store |
| pal_we | input | 1 | Colour-table write strobe |
| pal_waddr | input | IDX_W | Colour-table entry to write |
| pal_wdata | input | 3*CH_W | Colour value {red, green, blue} |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| de | output | 1 | High during visible pixels |
| red | output | CH_W | Red channel |
| green | output | CH_W | Green channel |
| blue | output | CH_W | Blue channel |

## Verification
The bench compares every clock of a whole frame with its own model. This exposes three kinds of fault. A design that drops the line repeat, or the column repeat, shows neighbouring pixels where duplicates belong. A design whose sync or valid pipeline is one stage shorter than the colour path shifts the image by a pixel against `de`. A design with a wrong porch or sync count breaks the column and line numbers at which the table entries sample the sync edges.

Directed cases cover the following. Index 127 must not be dropped by an off-by-one table depth. Writes made while the display is running must show in the next frame. Writes made during reset must not be lost. A reset in mid-frame must return the outputs to blank and restart the raster at the origin on the second clock.

// File: rtl/vscan_doubler.sv
module vscan_doubler #(
  parameter int FB_W   = 32,
  parameter int FB_H   = 24,
  parameter int IDX_W  = 7,
  parameter int CH_W   = 4,
  parameter int H_FP   = 4,
  parameter int H_SYNC = 8,
  parameter int H_BP   = 8,
  parameter int V_FP   = 1,
  parameter int V_SYNC = 2,
  parameter int V_BP   = 3
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 fb_we,
  input  logic [$clog2(FB_W)+$clog2(FB_H)-1:0] fb_waddr,
  input  logic [IDX_W-1:0]                     fb_wdata,
  input  logic                                 pal_we,
  input  logic [IDX_W-1:0]                     pal_waddr,
  input  logic [3*CH_W-1:0]                    pal_wdata,
  output logic                                 hsync_n,
  output logic                                 vsync_n,
  output logic                                 de,
  output logic [CH_W-1:0]                      red,
  output logic [CH_W-1:0]                      green,
  output logic [CH_W-1:0]                      blue
);

  localparam int XW    = $clog2(FB_W);
  localparam int YW    = $clog2(FB_H);
  localparam int AW    = XW + YW;
  localparam int DEPTH = FB_W * FB_H;
  localparam int PAL_N = 2 ** IDX_W;
  localparam int CW    = 3 * CH_W;

  localparam int H_ACT = 2 * FB_W;
  localparam int H_SS  = H_ACT + H_FP;
  localparam int H_SE  = H_SS + H_SYNC;
  localparam int H_TOT = H_SE + H_BP;
  localparam int V_ACT = 2 * FB_H;
  localparam int V_SS  = V_ACT + V_FP;
  localparam int V_SE  = V_SS + V_SYNC;
  localparam int V_TOT = V_SE + V_BP;
  localparam int HCW   = $clog2(H_TOT);
  localparam int VCW   = $clog2(V_TOT);

  localparam logic [HCW-1:0] H_ACT_C = HCW'(H_ACT);
  localparam logic [HCW-1:0] H_SS_C  = HCW'(H_SS);
  localparam logic [HCW-1:0] H_SE_C  = HCW'(H_SE);
  localparam logic [HCW-1:0] H_LAST  = HCW'(H_TOT - 1);
  localparam logic [VCW-1:0] V_ACT_C = VCW'(V_ACT);
  localparam logic [VCW-1:0] V_SS_C  = VCW'(V_SS);
  localparam logic [VCW-1:0] V_SE_C  = VCW'(V_SE);
  localparam logic [VCW-1:0] V_LAST  = VCW'(V_TOT - 1);

  logic [HCW-1:0]   hcnt;
  logic [VCW-1:0]   vcnt;
  logic [IDX_W-1:0] fb_mem  [DEPTH];
  logic [CW-1:0]    pal_mem [PAL_N];
  logic [IDX_W-1:0] pix;
  logic [CW-1:0]    col;
  logic [1:0]       de_q, hs_q, vs_q;

  wire h_end = (hcnt == H_LAST);
  wire v_end = (vcnt == V_LAST);
  wire act   = (hcnt < H_ACT_C) && (vcnt < V_ACT_C);
  wire hs_n  = !((hcnt >= H_SS_C) && (hcnt < H_SE_C));
  wire vs_n  = !((vcnt >= V_SS_C) && (vcnt < V_SE_C));
  wire [AW-1:0] rd_addr = {vcnt[YW:1], hcnt[XW:1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      hcnt <= '0;
      vcnt <= '0;
    end else if (h_end) begin
      hcnt <= '0;
      vcnt <= v_end ? '0 : vcnt + VCW'(1);
    end else begin
      hcnt <= hcnt + HCW'(1);
    end
  end

  always_ff @(posedge clk)
    if (fb_we && ({1'b0, fb_waddr} < (AW+1)'(DEPTH)))
      fb_mem[fb_waddr] <= fb_wdata;

  always_ff @(posedge clk)
    if (act && !hcnt[0])
      pix <= fb_mem[rd_addr];

  always_ff @(posedge clk)
    if (pal_we)
      pal_mem[pal_waddr] <= pal_wdata;

  always_ff @(posedge clk)
    col <= pal_mem[pix];

  always_ff @(posedge clk) begin
    if (rst) begin
      de_q <= 2'b00;
      hs_q <= 2'b11;
      vs_q <= 2'b11;
    end else begin
      de_q <= {de_q[0], act};
      hs_q <= {hs_q[0], hs_n};
      vs_q <= {vs_q[0], vs_n};
    end
  end

  assign de      = de_q[1];
  assign hsync_n = hs_q[1];
  assign vsync_n = vs_q[1];
  assign red     = de ? col[CW-1 -: CH_W]     : '0;
  assign green   = de ? col[2*CH_W-1 -: CH_W] : '0;
  assign blue    = de ? col[CH_W-1:0]         : '0;

  // R2
  h_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    h_end |=> (hcnt == '0));

  // R2
  h_step_chk: assert property (@(posedge clk) disable iff (rst)
    !h_end |=> (hcnt == $past(hcnt) + HCW'(1)));

  // R3
  v_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !h_end |=> $stable(vcnt));

  // R3
  v_range_chk: assert property (@(posedge clk) disable iff (rst)
    vcnt <= V_LAST);

  // R8
  de_align_chk: assert property (@(posedge clk) disable iff (rst)
    de |-> (($past(hcnt, 2) < H_ACT_C) && ($past(vcnt, 2) < V_ACT_C)));

  // R8
  hs_align_chk: assert property (@(posedge clk) disable iff (rst)
    !hsync_n |-> (($past(hcnt, 2) >= H_SS_C) && ($past(hcnt, 2) < H_SE_C)));

endmodule

// File: tb/vscan_doubler_tb.sv
`timescale 1ns/1ps
module vscan_doubler_tb;
  localparam int FW  = 32;
  localparam int FH  = 24;
  localparam int HA  = 2 * FW;
  localparam int HFP = 4;
  localparam int HSY = 8;
  localparam int HBP = 8;
  localparam int HT  = HA + HFP + HSY + HBP;
  localparam int VA  = 2 * FH;
  localparam int VFP = 1;
  localparam int VSY = 2;
  localparam int VBP = 3;
  localparam int VT  = VA + VFP + VSY + VBP;
  localparam int FT  = HT * VT;

  // {column[6:0], line[5:0], expected {de, hsync_n, vsync_n}}, ordered by raster position
  localparam int NT = 15;
  localparam logic [15:0] TAB [NT] = '{
    {7'd0,  6'd0,  3'b111},
    {7'd1,  6'd0,  3'b111},
    {7'd63, 6'd0,  3'b111},
    {7'd64, 6'd0,  3'b011},
    {7'd68, 6'd0,  3'b001},
    {7'd75, 6'd0,  3'b001},
    {7'd76, 6'd0,  3'b011},
    {7'd83, 6'd0,  3'b011},
    {7'd5,  6'd1,  3'b111},
    {7'd8,  6'd46, 3'b111},
    {7'd0,  6'd47, 3'b111},
    {7'd0,  6'd48, 3'b011},
    {7'd0,  6'd49, 3'b010},
    {7'd83, 6'd50, 3'b010},
    {7'd0,  6'd51, 3'b011}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fb_we = 1'b0;
  logic [9:0]  fb_waddr = '0;
  logic [6:0]  fb_wdata = '0;
  logic        pal_we = 1'b0;
  logic [6:0]  pal_waddr = '0;
  logic [11:0] pal_wdata = '0;
  logic        hsync_n, vsync_n, de;
  logic [3:0]  red, green, blue;

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [6:0]  fb_m  [FW*FH];
  logic [11:0] pal_m [128];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= rst ? 0 : cyc + 1;

  vscan_doubler u_dut (
    .clk(clk), .rst(rst),
    .fb_we(fb_we), .fb_waddr(fb_waddr), .fb_wdata(fb_wdata),
    .pal_we(pal_we), .pal_waddr(pal_waddr), .pal_wdata(pal_wdata),
    .hsync_n(hsync_n), .vsync_n(vsync_n), .de(de),
    .red(red), .green(green), .blue(blue)
  );

  function automatic logic [14:0] expect_at(int h, int v);
    logic e_de, e_hs, e_vs;
    logic [11:0] e_rgb;
    e_de  = (h < HA) && (v < VA);
    e_hs  = !((h >= HA + HFP) && (h < HA + HFP + HSY));
    e_vs  = !((v >= VA + VFP) && (v < VA + VFP + VSY));
    e_rgb = e_de ? pal_m[fb_m[(v / 2) * FW + (h / 2)]] : 12'h000;
    return {e_de, e_hs, e_vs, e_rgb};
  endfunction

  function automatic logic [14:0] obs();
    return {de, hsync_n, vsync_n, red, green, blue};
  endfunction

  task automatic check(string tag, logic [14:0] got, logic [14:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic at_pos(int f, int h, int v);
    int target;
    target = f * FT + v * HT + h + 2;
    while (cyc < target) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < FW * FH; i++) fb_m[i] = 7'(((i % FW) * 3 + (i / FW) * 5) % 128);
    for (int i = 0; i < 128; i++) pal_m[i] = 12'(i * 293 + 5);

    // R9: both tables are filled while reset is held
    for (int i = 0; i < FW * FH; i++) begin
      @(negedge clk);
      fb_we = 1'b1; fb_waddr = 10'(i); fb_wdata = fb_m[i];
    end
    @(negedge clk) fb_we = 1'b0;
    for (int i = 0; i < 128; i++) begin
      @(negedge clk);
      pal_we = 1'b1; pal_waddr = 7'(i); pal_wdata = pal_m[i];
    end
    @(negedge clk) pal_we = 1'b0;
    @(negedge clk);
    check("R1 reset state", obs(), {3'b011, 12'h000});
    rst = 1'b0;

    // Table walk over frame 0: sync/de flags (R2/R3/R4), then colour (R5/R6/R7)
    for (int i = 0; i < NT; i++) begin
      int h, v;
      h = int'(TAB[i][15:9]);
      v = int'(TAB[i][8:3]);
      at_pos(0, h, v);
      check("R2/R3/R4 table flags", {obs()[14:12], 12'h000}, {TAB[i][2:0], 12'h000});
      check("R5/R6/R7 table pixel", obs(), expect_at(h, v));
    end

    // Full sweep of frame 1: R5 doubling, R6 lookup, R7 blanking, R8 alignment
    for (int p = 0; p < FT; p++) begin
      at_pos(1, p % HT, p / HT);
      check("R5/R6/R7/R8 sweep", obs(), expect_at(p % HT, p / HT));
    end

    // R9: live writes while scanning, seen in frame 2
    @(negedge clk);
    fb_we = 1'b1; fb_waddr = 10'(2 * FW + 3); fb_wdata = 7'd100;
    @(negedge clk);
    fb_we = 1'b0;
    pal_we = 1'b1; pal_waddr = 7'd100; pal_wdata = 12'hABC;
    @(negedge clk);
    pal_we = 1'b0;
    fb_m[2 * FW + 3] = 7'd100;
    pal_m[100] = 12'hABC;
    at_pos(2, 6, 4);
    check("R9 live write (6,4)", obs(), {3'b111, 12'hABC});
    at_pos(2, 7, 5);
    check("R9 live write (7,5)", obs(), {3'b111, 12'hABC});

    // R10: stored index 127 at picture (4,23) resolves through entry 127
    at_pos(2, 8, 46);
    check("R10 index 127", obs(), {3'b111, pal_m[127]});

    // R1: reset in mid-frame, then restart at the origin
    @(negedge clk) rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R1 reset mid-frame", obs(), {3'b011, 12'h000});
    rst = 1'b0;
    @(negedge clk);
    check("R1/R8 first clock after release", obs(), {3'b011, 12'h000});
    @(negedge clk);
    check("R1/R8 origin on second clock", obs(), expect_at(0, 0));

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog (R1): actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule